// File: doc/BRIEF.md
# Infrared carrier modulator

This block turns a serial data stream into a signal that can drive an infrared LED directly. Two carrier waveforms, made by timers elsewhere, arrive as inputs. In amplitude-shift mode the block gates the first carrier with the data. In frequency-shift mode it switches between the two carriers according to the data. The output takes the place of the serial transmit pin.

The data comes from one of two places: the UART transmit line, or a bit that software writes. The block captures the chosen value into a register clocked by the carrier clock, so the output changes only on that clock. An inversion control sets the polarity of the LED drive. When the function is disabled, the pin carries the raw transmit line without any modulation.

Top module: `ir_carrier_mod`

## Requirements
- R1: When `ir_enable_i` is 0, `ir_pin_o` equals `uart_tx_i` combinationally, with no modulation applied.
- R2: When `ir_src_sw_i` is 0, the data value used for modulation is `uart_tx_i` as sampled at the latest rising edge of `clk`.
- R3: When `ir_src_sw_i` is 1, the data value used for modulation is `ir_sw_bit_i` as sampled at the latest rising edge of `clk`.
- R4: Amplitude-shift keying (`ir_fsk_i` = 0, `ir_invert_i` = 0): `ir_pin_o` equals `carrier_a_i` when the data is 1 and stays 0 when the data is 0.
- R5: Frequency-shift keying (`ir_fsk_i` = 1, `ir_invert_i` = 0) with data 1: `ir_pin_o` follows `carrier_a_i`.
- R6: Frequency-shift keying with data 0: `ir_pin_o` follows `carrier_b_i`.
- R7: With `ir_enable_i` = 1 and `ir_invert_i` = 1, `ir_pin_o` is the complement of the value R4 to R6 give. The inversion is applied after the mode selection.
- R8: A change on the selected data input has no effect on `ir_pin_o` until the next rising edge of `clk`.
- R9: While `rst_n` is low, the data register holds 0. With the function enabled in amplitude-shift mode and not inverted, `ir_pin_o` is then 0.
- R10: `ir_invert_i` has no effect on `ir_pin_o` while `ir_enable_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-domain clock that samples the data |
| rst_n | input | 1 | Asynchronous reset, active low |
| uart_tx_i | input | 1 | Serial transmit line from the UART |
| carrier_a_i | input | 1 | First carrier, from a timer |
| carrier_b_i | input | 1 | Second carrier, from a timer |
| ir_enable_i | input | 1 | 1 turns the modulator on |
| ir_invert_i | input | 1 | 1 inverts the modulated output |
| ir_fsk_i | input | 1 | 0 selects amplitude-shift, 1 selects frequency-shift |
| ir_src_sw_i | input | 1 | 0 takes data from the UART, 1 takes it from the software bit |
| ir_sw_bit_i | input | 1 | Data bit written by software |
| ir_pin_o | output | 1 | Drive for the LED pin |

## Verification
Each mode is driven with data 0 and data 1, and in each case the carriers are toggled on their own. A data-0 run in amplitude-shift mode shows whether the carrier is gated off or merely passed through. Frequency-shift runs with the two carriers set to opposite levels show which carrier was selected. Each test then flips the non-selected data source and the inversion control, which separates the correct source and inversion order from a wrong one. Data is also changed between clock edges, which shows whether the output waits for the register.

// File: rtl/ir_carrier_mod.sv
module ir_carrier_mod #(
  parameter logic DATA_RST = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uart_tx_i,
  input  logic carrier_a_i,
  input  logic carrier_b_i,
  input  logic ir_enable_i,
  input  logic ir_invert_i,
  input  logic ir_fsk_i,
  input  logic ir_src_sw_i,
  input  logic ir_sw_bit_i,
  output logic ir_pin_o
);

  logic data_q;
  logic data_d;
  logic mod_raw;

  assign data_d = ir_src_sw_i ? ir_sw_bit_i : uart_tx_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= DATA_RST;
    else        data_q <= data_d;
  end

  assign mod_raw  = ir_fsk_i ? (data_q ? carrier_a_i : carrier_b_i)
                             : (carrier_a_i & data_q);
  assign ir_pin_o = ir_enable_i ? (mod_raw ^ ir_invert_i) : uart_tx_i;

  // R4
  ask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!ir_src_sw_i && !uart_tx_i) && ir_enable_i && !ir_fsk_i && !ir_invert_i)
      |-> !ir_pin_o);

  // R5
  fsk_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ir_src_sw_i && ir_sw_bit_i) && ir_enable_i && ir_fsk_i && !ir_invert_i)
      |-> (ir_pin_o == carrier_a_i));

  // R6
  fsk_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ir_src_sw_i && !ir_sw_bit_i) && ir_enable_i && ir_fsk_i && !ir_invert_i)
      |-> (ir_pin_o == carrier_b_i));

  // R7
  inv_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ir_src_sw_i && !ir_sw_bit_i) && ir_enable_i && !ir_fsk_i && ir_invert_i)
      |-> ir_pin_o);

endmodule

// File: tb/ir_carrier_mod_tb.sv
module ir_carrier_mod_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx = 1'b0, ca = 1'b0, cb = 1'b0;
  logic en = 1'b0, inv = 1'b0, fsk = 1'b0, src = 1'b0, swb = 1'b0;
  logic pin;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  ir_carrier_mod dut_i (
    .clk(clk), .rst_n(rst_n), .uart_tx_i(tx), .carrier_a_i(ca), .carrier_b_i(cb),
    .ir_enable_i(en), .ir_invert_i(inv), .ir_fsk_i(fsk), .ir_src_sw_i(src),
    .ir_sw_bit_i(swb), .ir_pin_o(pin)
  );

  task automatic chk(input string req, input logic exp);
    total++;
    if (pin !== exp) begin
      bad++;
      $display("FAIL %s: pin=%b expected=%b", req, pin, exp);
    end
  endtask

  task automatic load(input logic s, input logic b, input logic t);
    @(negedge clk);
    src = s; swb = b; tx = t;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    en = 1; fsk = 0; inv = 0; ca = 1; tx = 1; src = 0;
    #1 chk("R9 reset data 0", 1'b0);
    repeat (2) @(posedge clk);
    #1 chk("R9 held in reset", 1'b0);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_bypass;
    en = 0;
    for (int i = 0; i < 4; i++) begin
      tx = i[0]; inv = i[1]; ca = ~i[0]; #1;
      chk("R1 bypass", i[0]);
      chk("R10 invert ignored", i[0]);
    end
  endtask

  task automatic t_ask;
    en = 1; fsk = 0; inv = 0;
    load(0, 1, 1);
    ca = 1; #1 chk("R4 ask data1 ca1", 1'b1);
    ca = 0; #1 chk("R4 ask data1 ca0", 1'b0);
    chk("R2 uart source", 1'b0);
    load(0, 1, 0);
    ca = 1; #1 chk("R4 ask data0 gated", 1'b0);
    chk("R2 uart 0 ignores sw bit", 1'b0);
    load(1, 1, 0);
    #1 chk("R3 sw source 1", 1'b1);
    load(1, 0, 1);
    #1 chk("R3 sw source 0 ignores uart", 1'b0);
  endtask

  task automatic t_fsk;
    en = 1; fsk = 1; inv = 0;
    load(1, 1, 0);
    ca = 1; cb = 0; #1 chk("R5 fsk mark a=1", 1'b1);
    ca = 0; cb = 1; #1 chk("R5 fsk mark a=0", 1'b0);
    load(1, 0, 1);
    ca = 1; cb = 0; #1 chk("R6 fsk space b=0", 1'b0);
    ca = 0; cb = 1; #1 chk("R6 fsk space b=1", 1'b1);
  endtask

  task automatic t_invert;
    en = 1; inv = 1;
    fsk = 0; load(1, 0, 0);
    ca = 1; #1 chk("R7 ask data0 inverted", 1'b1);
    load(1, 1, 0);
    ca = 1; #1 chk("R7 ask data1 inverted", 1'b0);
    fsk = 1; load(1, 0, 0);
    ca = 0; cb = 1; #1 chk("R7 fsk space inverted", 1'b0);
    inv = 0;
  endtask

  task automatic t_latency;
    en = 1; fsk = 0; inv = 0; ca = 1;
    load(0, 0, 0);
    @(negedge clk) tx = 1; #1;
    chk("R8 no change before edge", 1'b0);
    @(posedge clk); #1;
    chk("R8 change after edge", 1'b1);
    @(negedge clk) src = 1; swb = 0; #1;
    chk("R8 source switch waits", 1'b1);
    @(posedge clk); #1;
    chk("R8 source switch applied", 1'b0);
  endtask

  initial begin
    t_reset;
    t_bypass;
    t_ask;
    t_fsk;
    t_invert;
    t_latency;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #50000;
    total++; bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule